// File: doc/BRIEF.md
# Interleaved Dual-Codeword Reed-Solomon Parity Encoder

This block turns a 256-byte payload into two systematic Reed-Solomon codewords of 160 bytes each, built as one stream. Payload bytes enter one per valid strobe. Each byte is forwarded unchanged to the output one clock later. At the same time it is folded into one of two parity shift registers: even payload positions feed codeword 0 and odd positions feed codeword 1. The payload is therefore never stored. When the last payload byte has been taken, the block streams the 64 parity bytes on consecutive clocks. It alternates between the codewords in the same even/odd pattern as the data, and gives the highest-degree parity symbol of each codeword first.

The code is over GF(256) with field polynomial x^8+x^7+x^2+x+1, using plain polynomial-basis symbols. The generator has the 32 roots α^(11j), j = 112..143, where α is the element 0x02. Each codeword is a shortened form of the 255-symbol code. The 95 leading symbols are implied zeros, and the encoder spends no cycles on them. A start-of-frame pulse clears both parity registers and opens a new frame. Payload strobes outside an open frame are dropped.

Top module: `rsenc_dual`

## Requirements
- R1: After reset, and until the first start-of-frame pulse, `out_valid`, `out_parity` and `out_last` stay low, whatever `in_valid` does.
- R2: In an open frame, each byte accepted at a rising edge appears on `out_data` at that same edge, with `out_valid` high and `out_parity` low. Its observed latency is one clock from when the byte is presented.
- R3: Payload byte 2k is encoded into codeword 0 and byte 2k+1 into codeword 1. A payload whose even bytes are all zero gives all-zero codeword-0 parity.
- R4: The edge after the 256th payload byte starts 64 parity bytes on 64 consecutive edges, each with `out_valid` and `out_parity` high. Parity byte n belongs to codeword n mod 2 and is that codeword's coefficient of x^(31 - n/2).
- R5: Each 160-byte codeword is zero when evaluated at all 32 roots α^(11j), j = 112..143. The codeword is read as a polynomial with its first byte at the highest degree: 128 payload bytes of that codeword, then its 32 parity bytes.
- R6: Idle cycles between payload strobes are allowed. Parity depends only on the accepted bytes and their order.
- R7: Strobes that arrive while parity is being emitted, or after a frame has ended, produce no output and do not change any parity byte.
- R8: A start-of-frame pulse clears both parity registers and restarts the byte count. The output is silent on the next edge. A pulse that arrives during data or parity aborts the frame in progress.
- R9: `out_last` is high only with the 64th parity byte of a frame.
- R10: An all-zero payload gives 64 zero parity bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start-of-frame pulse; clears parity state |
| in_valid | input | 1 | Payload byte strobe |
| in_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Forwarded payload byte or parity byte |
| out_parity | output | 1 | High when `out_data` carries parity |
| out_last | output | 1 | High on the final parity byte of a frame |

## Verification
Every output comes from one register stage. A payload byte presented before rising edge E is seen after E. The first parity byte follows the edge after the last payload byte, and a start-of-frame pulse sampled at E silences the output right after E. The bench samples a quarter period after each rising edge. At that point its behavioural model has absorbed the inputs sampled at the same edge, so expectation and output always refer to the same edge. Parity values come from long division by a generator the bench builds from the roots. Each captured codeword is then also evaluated at every root.

// File: rtl/rsenc_pkg.sv
package rsenc_pkg;

   localparam int SYM_W   = 8;
   localparam int MAX_PAR = 64;

   typedef logic [SYM_W-1:0]  sym_t;
   typedef sym_t [MAX_PAR:0]  gpoly_t;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DATA = 2'd1,
      PH_PAR  = 2'd2
   } phase_e;

   // Polynomial-basis product; red holds the field polynomial without x^8.
   function automatic sym_t gf_mul(input sym_t a, input sym_t b, input sym_t red);
      sym_t acc;
      sym_t t;
      acc = '0;
      t   = a;
      for (int i = 0; i < SYM_W; i++) begin
         if (b[i]) acc = acc ^ t;
         t = t[SYM_W-1] ? ((t << 1) ^ red) : (t << 1);
      end
      return acc;
   endfunction

   function automatic sym_t gf_pow(input int e, input sym_t red);
      sym_t r;
      r = 8'h01;
      for (int i = 0; i < (e % 255); i++) r = gf_mul(r, 8'h02, red);
      return r;
   endfunction

   // Product of (x + alpha^(step*(fcr+k))) for k in 0..npar-1, coefficient i of x^i.
   function automatic gpoly_t gen_poly(input int npar, input int fcr,
                                       input int step, input sym_t red);
      gpoly_t g;
      sym_t   root;
      g    = '0;
      g[0] = 8'h01;
      for (int k = 0; k < npar; k++) begin
         root = gf_pow((step * (fcr + k)) % 255, red);
         for (int i = k + 1; i >= 1; i--) g[i] = g[i-1] ^ gf_mul(g[i], root, red);
         g[0] = gf_mul(g[0], root, red);
      end
      return g;
   endfunction

endpackage

// File: rtl/rsenc_seq.sv
module rsenc_seq
   import rsenc_pkg::*;
#(
   parameter int N_CW   = 2,
   parameter int DATA_N = 128,
   parameter int PAR_N  = 32,
   localparam int SEL_W = (N_CW > 1) ? $clog2(N_CW) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof_i,
   input  logic             in_valid_i,
   output logic             take_o,
   output logic             emit_o,
   output logic             last_o,
   output logic [SEL_W-1:0] sel_o
);

   localparam int DATA_TOT = N_CW * DATA_N;
   localparam int PAR_TOT  = N_CW * PAR_N;
   localparam int CNT_MAX  = (DATA_TOT > PAR_TOT) ? DATA_TOT : PAR_TOT;
   localparam int CNT_W    = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] DATA_END = CNT_W'(DATA_TOT - 1);
   localparam logic [CNT_W-1:0] PAR_END  = CNT_W'(PAR_TOT - 1);

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign take_o = (phase_q == PH_DATA) && in_valid_i && !sof_i;
   assign emit_o = (phase_q == PH_PAR) && !sof_i;
   assign last_o = emit_o && (cnt_q == PAR_END);
   assign step   = take_o || emit_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (sof_i) begin
         phase_q <= PH_DATA;
         cnt_q   <= '0;
      end else if (take_o) begin
         if (cnt_q == DATA_END) begin
            phase_q <= PH_PAR;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (emit_o) begin
         if (cnt_q == PAR_END) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   generate
      if (N_CW > 1) begin : g_multi
         logic [SEL_W-1:0] sel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sel_q <= '0;
            else if (sof_i)  sel_q <= '0;
            else if (step)   sel_q <= (sel_q == SEL_W'(N_CW - 1)) ? '0 : sel_q + 1'b1;
         end
         assign sel_o = sel_q;
      end else begin : g_single
         assign sel_o = '0;
      end
   endgenerate

   // Data and parity phases never overlap: emitting only once data is complete.
   assert_no_take_emit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(take_o && emit_o));

   // After the final parity byte the sequencer no longer emits (R7).
   assert_quiet_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> !emit_o);

endmodule

// File: rtl/rsenc_lfsr.sv
module rsenc_lfsr
   import rsenc_pkg::*;
#(
   parameter int     PAR_N      = 32,
   parameter sym_t   FIELD_RED  = 8'h87,
   parameter gpoly_t GEN        = '0,
   parameter bit     SHARE_TAPS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic upd_i,
   input  logic shift_i,
   input  sym_t din_i,
   output sym_t top_o
);

   localparam int HALF = PAR_N / 2;

   sym_t stage_q [PAR_N];
   sym_t prod    [PAR_N];
   sym_t fb;

   assign fb    = din_i ^ stage_q[PAR_N-1];
   assign top_o = stage_q[PAR_N-1];

   generate
      if (SHARE_TAPS) begin : g_share
         // Mirror-image coefficients share one multiplier.
         sym_t uniq [HALF+1];
         for (genvar i = 0; i <= HALF; i++) begin : g_u
            assign uniq[i] = gf_mul(fb, GEN[i], FIELD_RED);
         end
         for (genvar i = 0; i < PAR_N; i++) begin : g_m
            localparam int SRC = (i <= HALF) ? i : (PAR_N - i);
            assign prod[i] = uniq[SRC];
         end
      end else begin : g_full
         for (genvar i = 0; i < PAR_N; i++) begin : g_m
            assign prod[i] = gf_mul(fb, GEN[i], FIELD_RED);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PAR_N; i++) stage_q[i] <= '0;
      end else if (clr_i) begin
         for (int i = 0; i < PAR_N; i++) stage_q[i] <= '0;
      end else if (upd_i) begin
         stage_q[0] <= prod[0];
         for (int i = 1; i < PAR_N; i++) stage_q[i] <= stage_q[i-1] ^ prod[i];
      end else if (shift_i) begin
         stage_q[0] <= '0;
         for (int i = 1; i < PAR_N; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   // A start-of-frame clear leaves the register empty at its output stage.
   assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (top_o == '0));

   // Only one of update and shift is requested in a cycle.
   assert_upd_shift_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_i && shift_i));

endmodule

// File: rtl/rsenc_dual.sv
module rsenc_dual
   import rsenc_pkg::*;
#(
   parameter int         N_CW       = 2,
   parameter int         DATA_N     = 128,
   parameter int         PAR_N      = 32,
   parameter int         FCR        = 112,
   parameter int         ROOT_STEP  = 11,
   parameter logic [8:0] FIELD_POLY = 9'h187,
   parameter bit         SHARE_TAPS = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sof_i,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   output logic       out_valid,
   output logic [7:0] out_data,
   output logic       out_parity,
   output logic       out_last
);

   localparam sym_t   FIELD_RED = FIELD_POLY[7:0];
   localparam gpoly_t GEN       = gen_poly(PAR_N, FCR, ROOT_STEP, FIELD_RED);
   localparam int     SEL_W     = (N_CW > 1) ? $clog2(N_CW) : 1;
   localparam bit     IS_STD    = (PAR_N == 32) && (FCR == 112) && (ROOT_STEP == 11)
                                  && (FIELD_POLY == 9'h187);

   // Elaboration-time parameter checks.
   generate
      if (N_CW < 1) begin : g_bad_ncw
         $error("N_CW must be at least 1");
      end
      if ((PAR_N < 2) || (PAR_N > MAX_PAR) || ((PAR_N % 2) != 0)) begin : g_bad_par
         $error("PAR_N must be even and within 2..MAX_PAR");
      end
      if ((DATA_N < 1) || (DATA_N + PAR_N > 255)) begin : g_bad_len
         $error("codeword length exceeds the field size");
      end
      if (FIELD_POLY[8] != 1'b1) begin : g_bad_poly
         $error("field polynomial must have degree 8");
      end
      if (GEN[PAR_N] != 8'h01) begin : g_bad_monic
         $error("generator is not monic");
      end
      if (SHARE_TAPS) begin : g_pal_chk
         for (genvar i = 0; i <= PAR_N; i++) begin : g_pal
            if (GEN[i] != GEN[PAR_N-i]) begin : g_bad_pal
               $error("shared taps need a palindromic generator");
            end
         end
      end
      if (IS_STD) begin : g_std_chk
         if ((GEN[1] != gf_pow(249, FIELD_RED)) || (GEN[16] != gf_pow(24, FIELD_RED))
             || (GEN[9] != gf_pow(30, FIELD_RED))) begin : g_bad_coef
            $error("generator coefficients differ from the expected code");
         end
      end
   endgenerate

   logic             take;
   logic             emit;
   logic             last;
   logic [SEL_W-1:0] sel;
   sym_t             tops [N_CW];

   rsenc_seq #(
      .N_CW   (N_CW),
      .DATA_N (DATA_N),
      .PAR_N  (PAR_N)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sof_i      (sof_i),
      .in_valid_i (in_valid),
      .take_o     (take),
      .emit_o     (emit),
      .last_o     (last),
      .sel_o      (sel)
   );

   generate
      for (genvar k = 0; k < N_CW; k++) begin : g_cw
         logic mine;
         assign mine = (sel == SEL_W'(k));
         rsenc_lfsr #(
            .PAR_N      (PAR_N),
            .FIELD_RED  (FIELD_RED),
            .GEN        (GEN),
            .SHARE_TAPS (SHARE_TAPS)
         ) u_par (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (sof_i),
            .upd_i   (take && mine),
            .shift_i (emit && mine),
            .din_i   (in_data),
            .top_o   (tops[k])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_parity <= 1'b0;
         out_last   <= 1'b0;
         out_data   <= '0;
      end else begin
         out_valid  <= take || emit;
         out_parity <= emit;
         out_last   <= last;
         if (take)      out_data <= in_data;
         else if (emit) out_data <= tops[sel];
      end
   end

   // An accepted payload byte is forwarded unchanged on the next edge.
   assert_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (out_valid && !out_parity && (out_data == $past(in_data))));

   // Parity bytes run back to back until the last one, unless a new frame opens.
   assert_par_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_parity && !out_last && !sof_i) |=> (out_valid && out_parity));

   // The last flag only accompanies a parity byte.
   assert_last_is_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (out_valid && out_parity));

   // After the final parity byte the output falls silent.
   assert_silent_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |=> !out_valid);

   // A start-of-frame pulse silences the next output cycle.
   assert_sof_silences_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sof_i |=> !out_valid);

endmodule

// File: tb/rsenc_dual_tb.sv
module rsenc_dual_tb;

   localparam int NPAR  = 32;
   localparam int NDAT  = 128;
   localparam int NTOT  = NDAT + NPAR;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sof_i = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       out_valid;
   logic [7:0] out_data;
   logic       out_parity;
   logic       out_last;

   always #10 clk = ~clk;

   rsenc_dual u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sof_i      (sof_i),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .out_parity (out_parity),
      .out_last   (out_last)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // Field arithmetic through log / antilog tables.
   int alog [0:254];
   int lg   [0:255];
   int gpl  [0:NPAR];

   function automatic int gfm(input int a, input int b);
      if (a == 0 || b == 0) return 0;
      return alog[(lg[a] + lg[b]) % 255];
   endfunction

   task automatic build_field();
      int v;
      v = 1;
      for (int i = 0; i < 255; i++) begin
         alog[i] = v;
         lg[v]   = i;
         v = v << 1;
         if (v & 256) v = v ^ 'h187;
      end
      lg[0] = 0;
      for (int i = 0; i <= NPAR; i++) gpl[i] = 0;
      gpl[0] = 1;
      for (int k = 0; k < NPAR; k++) begin
         int r;
         r = alog[(11 * (112 + k)) % 255];
         for (int i = k + 1; i >= 1; i--) gpl[i] = gpl[i-1] ^ gfm(gpl[i], r);
         gpl[0] = gfm(gpl[0], r);
      end
   endtask

   // Reference model state.
   int mst = 0;           // 0 idle, 1 data, 2 parity
   int mcnt = 0;
   int mbuf [0:1][0:NDAT-1];
   int mpar [0:1][0:NPAR-1];
   bit       e_valid = 1'b0;
   bit       e_par   = 1'b0;
   bit       e_last  = 1'b0;
   int       e_data  = 0;

   // Captured output of the current frame.
   int cap_d [0:255];
   int cap_p [0:63];
   int cd = 0;
   int cp = 0;

   task automatic make_parity(input int cw);
      int c [0:NTOT-1];
      for (int i = 0; i < NDAT; i++) c[i] = mbuf[cw][i];
      for (int i = NDAT; i < NTOT; i++) c[i] = 0;
      for (int i = 0; i < NDAT; i++) begin
         int coef;
         coef = c[i];
         if (coef != 0)
            for (int j = 0; j <= NPAR; j++) c[i+j] = c[i+j] ^ gfm(coef, gpl[NPAR-j]);
      end
      for (int k = 0; k < NPAR; k++) mpar[cw][k] = c[NDAT+k];
   endtask

   task automatic fail_line(input string tag, input string what, input int act, input int exp);
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
   endtask

   // Model advance and comparison a quarter period after each rising edge.
   always @(posedge clk) begin
      #5;
      if (!rst_n) begin
         mst = 0; mcnt = 0; e_valid = 0; e_par = 0; e_last = 0;
         n_cmp++;
         if (out_valid !== 1'b0 || out_parity !== 1'b0 || out_last !== 1'b0)
            fail_line("R1", "outputs in reset", int'({out_valid, out_parity, out_last}), 0);
      end else begin
         if (sof_i) begin
            mst = 1; mcnt = 0; e_valid = 0; e_par = 0; e_last = 0;
            cd = 0; cp = 0;
         end else if (mst == 1 && in_valid) begin
            e_valid = 1; e_par = 0; e_last = 0; e_data = int'(in_data);
            mbuf[mcnt % 2][mcnt / 2] = int'(in_data);
            if (mcnt == 255) begin
               make_parity(0);
               make_parity(1);
               mst = 2; mcnt = 0;
            end else mcnt++;
         end else if (mst == 2) begin
            e_valid = 1; e_par = 1;
            e_data = mpar[mcnt % 2][mcnt / 2];
            e_last = (mcnt == 63);
            if (mcnt == 63) begin mst = 0; mcnt = 0; end
            else mcnt++;
         end else begin
            e_valid = 0; e_par = 0; e_last = 0;
         end
         n_cmp++;
         if (out_valid !== e_valid) begin
            fail_line(e_valid ? (e_par ? "R4" : "R2") : "R7", "out_valid",
                      int'(out_valid), int'(e_valid));
         end else if (e_valid) begin
            if (out_parity !== e_par) fail_line("R4", "out_parity", int'(out_parity), int'(e_par));
            else if (out_data !== 8'(e_data))
               fail_line(e_par ? "R4" : "R2", "out_data", int'(out_data), e_data);
            else if (out_last !== e_last) fail_line("R9", "out_last", int'(out_last), int'(e_last));
         end
         if (out_valid === 1'b1) begin
            if (out_parity === 1'b1) begin
               if (cp < 64) cap_p[cp] = int'(out_data);
               cp++;
            end else begin
               if (cd < 256) cap_d[cd] = int'(out_data);
               cd++;
            end
         end
      end
   end

   int seed = 12345;
   function automatic int next_rand();
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      return (seed >> 16) & 8'hff;
   endfunction

   task automatic open_frame();
      @(negedge clk);
      in_valid = 1'b0;
      sof_i = 1'b1;
      @(negedge clk);
      sof_i = 1'b0;
   endtask

   function automatic int pattern(input int mode, input int i);
      case (mode)
         0: return (i * 7 + 3) & 8'hff;
         1: return next_rand();
         2: return 0;
         default: return (i % 2) ? (((i * 13) | 1) & 8'hff) : 0;
      endcase
   endfunction

   // mode picks the payload; gaps inserts idle cycles; junk strobes through parity.
   task automatic send_bytes(input int mode, input int count, input bit gaps);
      for (int i = 0; i < count; i++) begin
         if (gaps && (i % 5 == 3)) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data = 8'h5a;
         end
         @(negedge clk);
         in_valid = 1'b1;
         in_data = 8'(pattern(mode, i));
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic tail(input bit junk, input int cycles);
      for (int i = 0; i < cycles; i++) begin
         in_valid = junk;
         in_data = 8'(i * 37 + 11);
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic check_roots(input string tag);
      n_cmp++;
      if (cd != 256 || cp != 64) begin
         fail_line("R4", "captured byte count", cd * 1000 + cp, 256064);
         return;
      end
      for (int cw = 0; cw < 2; cw++) begin
         int bad;
         bad = 0;
         for (int j = 112; j <= 143; j++) begin
            int r;
            int acc;
            r = alog[(11 * j) % 255];
            acc = 0;
            for (int i = 0; i < NDAT; i++) acc = gfm(acc, r) ^ cap_d[2 * i + cw];
            for (int i = 0; i < NPAR; i++) acc = gfm(acc, r) ^ cap_p[2 * i + cw];
            if (acc != 0) bad++;
         end
         n_cmp++;
         if (bad != 0) fail_line(tag, "nonzero root evaluations", bad, 0);
      end
   endtask

   task automatic check_par_zero(input string tag, input int cw, input bit want_zero);
      int nz;
      nz = 0;
      for (int i = 0; i < NPAR; i++) if (cap_p[2 * i + cw] != 0) nz++;
      n_cmp++;
      if (want_zero && nz != 0) fail_line(tag, "nonzero parity bytes", nz, 0);
      if (!want_zero && nz == 0) fail_line(tag, "nonzero parity bytes", 0, 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      build_field();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: strobes before any start-of-frame give no output.
      tail(1'b1, 12);

      // R2 R4 R5: counting pattern, no gaps.
      open_frame();
      send_bytes(0, 256, 1'b0);
      tail(1'b0, 70);
      check_roots("R5");

      // R6 R7: pseudo-random payload with gaps, strobes held through parity.
      open_frame();
      send_bytes(1, 256, 1'b1);
      tail(1'b1, 80);
      check_roots("R6");

      // R10: all-zero payload.
      open_frame();
      send_bytes(2, 256, 1'b0);
      tail(1'b0, 70);
      check_par_zero("R10", 0, 1'b1);
      check_par_zero("R10", 1, 1'b1);

      // R3: only odd positions carry data.
      open_frame();
      send_bytes(3, 256, 1'b0);
      tail(1'b0, 70);
      check_par_zero("R3", 0, 1'b1);
      check_par_zero("R3", 1, 1'b0);
      check_roots("R3");

      // R8: abort mid-data, run a frame, abort mid-parity, then a clean frame.
      open_frame();
      send_bytes(1, 100, 1'b0);
      open_frame();
      send_bytes(0, 256, 1'b0);
      tail(1'b0, 20);
      open_frame();
      tail(1'b1, 10);
      send_bytes(1, 256, 1'b1);
      tail(1'b0, 70);
      check_roots("R8");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule